// File: doc/BRIEF.md
# DMA Control and Status Register File

This block is the register file that software uses to steer a descriptor-driven network DMA engine pair. It sits on a simple 32-bit register bus made of an address, a write strobe, write data and combinational read data. It holds four things. First, a mode word that carries a data-buffer byte-order select, a descriptor gap measured in 32-bit words, a transmit/receive bus-priority select and a software reset request. Second, two poll-demand locations, one per direction, that wake a suspended engine. Third and fourth, the base addresses of the transmit and receive descriptor rings.

Each engine reports its state as a 2-bit code: 00 stopped, 01 running, 10 suspended, 11 treated as running. Configuration that an engine depends on changes only while that engine is stopped. A poll demand goes through only while its engine is suspended, and it reaches the engine as a single-cycle strobe. The software reset request stays set until the reset sequencer raises its done input.

Top module: `dma_csr_regs`

## Requirements
- R1: After synchronous reset, all configuration outputs and base addresses are zero, both poll strobes are low, and the mode word reads back as 0.
- R2: A write to offset 00h while both engines are stopped stores bit 7 as the byte order (1 = big endian), bits 6:2 as the descriptor gap and bit 1 as the priority select (1 = transmit first). The mode word reads back with the same layout, and bit 0 shows the reset request.
- R3: A write to offset 00h while either engine is not stopped is ignored, and the stored mode is unchanged.
- R4: A 1 written to bit 0 of the mode word sets the reset request. A 0 written there does not clear it. The request clears in the cycle after `reset_done` is sampled high and stays set until then.
- R5: A write of any value to offset 08h while the transmit engine is suspended (10) raises `tx_poll` for exactly the one cycle after the write. In any other transmit state the write raises no strobe.
- R6: A write of any value to offset 10h while the receive engine is suspended raises `rx_poll` for exactly the one cycle after the write. In any other receive state it raises no strobe.
- R7: Offsets 08h and 10h always read as FFFFFFFFh.
- R8: Offset 18h holds the receive ring base. Bits 31:2 are writable only while the receive engine is stopped, regardless of the transmit state. Bits 1:0 always read 00.
- R9: Offset 20h holds the transmit ring base. Bits 31:2 are writable only while the transmit engine is stopped. Bits 1:0 always read 00.
- R10: Reads from any other offset return 0, and writes to them change no register or output.
- R11: Read data follows the address combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tx_state | input | 2 | Transmit engine state code |
| rx_state | input | 2 | Receive engine state code |
| reset_done | input | 1 | Reset sequence finished |
| big_endian | output | 1 | Data-buffer byte order |
| desc_gap | output | 5 | Gap between descriptors in words |
| tx_first | output | 1 | Transmit has bus priority |
| soft_reset | output | 1 | Software reset request |
| tx_poll | output | 1 | Transmit poll strobe |
| rx_poll | output | 1 | Receive poll strobe |
| rx_ring_base | output | 32 | Receive descriptor ring base |
| tx_ring_base | output | 32 | Transmit descriptor ring base |

## Verification
The hardest case to reach is the interaction of write acceptance with engine state. A write to a protected field or a poll location has to land while the engines are in a mix of states, for example one suspended and the other stopped. Only then does it show whether each gate looks at the right engine. The vector table sets both state codes on every write and reads the target back afterwards, so each rejected write appears as an unchanged value. Directed steps then hold the reset request across several cycles and a 0 write before they pulse `reset_done`.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int GAP_W  = 5;
    localparam int N_ENG  = 2;   // index 0 = transmit, 1 = receive

    localparam logic [ADDR_W-1:0] OFF_MODE    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_TX_POLL = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_RX_POLL = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_RX_BASE = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_TX_BASE = 8'h20;

    localparam logic [DATA_W-1:0] POLL_READ = '1;

    typedef enum logic [1:0] {
        ENG_STOPPED   = 2'b00,
        ENG_RUNNING   = 2'b01,
        ENG_SUSPENDED = 2'b10,
        ENG_BUSY      = 2'b11
    } eng_state_e;

    typedef struct packed {
        logic             big_endian;
        logic [GAP_W-1:0] gap;
        logic             tx_first;
        logic             rst_req;
    } mode_t;

    function automatic logic eng_stopped(input logic [1:0] st);
        return eng_state_e'(st) == ENG_STOPPED;
    endfunction

    function automatic logic eng_suspended(input logic [1:0] st);
        return eng_state_e'(st) == ENG_SUSPENDED;
    endfunction

    function automatic logic [DATA_W-1:0] word_align(input logic [DATA_W-1:0] a);
        return a & ~DATA_W'(3);
    endfunction

    function automatic logic [ADDR_W-1:0] poll_offset(input int idx);
        return (idx == 0) ? OFF_TX_POLL : OFF_RX_POLL;
    endfunction

    function automatic logic [ADDR_W-1:0] base_offset(input int idx);
        return (idx == 0) ? OFF_TX_BASE : OFF_RX_BASE;
    endfunction

endpackage

// File: rtl/dma_csr_mode.sv
module dma_csr_mode
    import dma_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_ok,
    input  logic [$bits(mode_t)-1:0] wdata,
    input  logic               reset_done,
    output mode_t              mode
);
    mode_t wr_val;
    assign wr_val = mode_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else begin
            if (reset_done)
                mode.rst_req <= 1'b0;
            if (wr_ok) begin
                mode.big_endian <= wr_val.big_endian;
                mode.gap        <= wr_val.gap;
                mode.tx_first   <= wr_val.tx_first;
                if (wr_val.rst_req)
                    mode.rst_req <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_csr_base.sv
module dma_csr_base
    import dma_csr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_ok,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] base
);
    always_ff @(posedge clk) begin
        if (rst)
            base <= '0;
        else if (wr_ok)
            base <= wdata & ~W'(3);
    end
endmodule

// File: rtl/dma_csr_poll.sv
module dma_csr_poll (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic strobe
);
    always_ff @(posedge clk) begin
        if (rst)
            strobe <= 1'b0;
        else
            strobe <= fire;
    end
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
    import dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        tx_state,
    input  logic [1:0]        rx_state,
    input  logic              reset_done,
    output logic              big_endian,
    output logic [GAP_W-1:0]  desc_gap,
    output logic              tx_first,
    output logic              soft_reset,
    output logic              tx_poll,
    output logic              rx_poll,
    output logic [DATA_W-1:0] rx_ring_base,
    output logic [DATA_W-1:0] tx_ring_base
);
    localparam int MODE_W = $bits(mode_t);

    logic [1:0]        eng_st   [N_ENG];
    logic [DATA_W-1:0] eng_base [N_ENG];
    logic              eng_poll [N_ENG];
    mode_t             mode;
    logic              all_stopped;
    logic              mode_wr;

    assign eng_st[0] = tx_state;
    assign eng_st[1] = rx_state;

    assign all_stopped = eng_stopped(tx_state) && eng_stopped(rx_state);
    assign mode_wr     = bus_wr && (bus_addr == OFF_MODE) && all_stopped;

    dma_csr_mode u_mode (
        .clk        (clk),
        .rst        (rst),
        .wr_ok      (mode_wr),
        .wdata      (bus_wdata[MODE_W-1:0]),
        .reset_done (reset_done),
        .mode       (mode)
    );

    for (genvar i = 0; i < N_ENG; i++) begin : g_eng
        localparam logic [ADDR_W-1:0] P_OFF = poll_offset(i);
        localparam logic [ADDR_W-1:0] B_OFF = base_offset(i);
        logic poll_fire;
        logic base_wr;

        assign poll_fire = bus_wr && (bus_addr == P_OFF) && eng_suspended(eng_st[i]);
        assign base_wr   = bus_wr && (bus_addr == B_OFF) && eng_stopped(eng_st[i]);

        dma_csr_poll u_poll (
            .clk    (clk),
            .rst    (rst),
            .fire   (poll_fire),
            .strobe (eng_poll[i])
        );

        dma_csr_base #(.W(DATA_W)) u_base (
            .clk   (clk),
            .rst   (rst),
            .wr_ok (base_wr),
            .wdata (bus_wdata),
            .base  (eng_base[i])
        );
    end

    always_comb begin
        unique case (bus_addr)
            OFF_MODE:    bus_rdata = DATA_W'(mode);
            OFF_TX_POLL,
            OFF_RX_POLL: bus_rdata = POLL_READ;
            OFF_RX_BASE: bus_rdata = word_align(eng_base[1]);
            OFF_TX_BASE: bus_rdata = word_align(eng_base[0]);
            default:     bus_rdata = '0;
        endcase
    end

    assign big_endian   = mode.big_endian;
    assign desc_gap     = mode.gap;
    assign tx_first     = mode.tx_first;
    assign soft_reset   = mode.rst_req;
    assign tx_poll      = eng_poll[0];
    assign rx_poll      = eng_poll[1];
    assign tx_ring_base = eng_base[0];
    assign rx_ring_base = eng_base[1];
endmodule

// File: rtl/dma_csr_regs_chk.sv
module dma_csr_regs_chk
    import dma_csr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [1:0]        tx_state,
    input logic [1:0]        rx_state,
    input logic              reset_done,
    input logic              big_endian,
    input logic [GAP_W-1:0]  desc_gap,
    input logic              tx_first,
    input logic              soft_reset,
    input logic              tx_poll,
    input logic              rx_poll,
    input logic [DATA_W-1:0] rx_ring_base,
    input logic [DATA_W-1:0] tx_ring_base
);
    p_tx_poll_cause_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_TX_POLL && tx_state == 2'b10) |=> tx_poll);
    p_tx_poll_only_r5: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFF_TX_POLL && tx_state == 2'b10) |=> !tx_poll);
    p_rx_poll_only_r6: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFF_RX_POLL && rx_state == 2'b10) |=> !rx_poll);
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_state != 2'b00 || rx_state != 2'b00)
        |=> $stable({big_endian, desc_gap, tx_first}));
    p_rx_base_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_state != 2'b00) |=> $stable(rx_ring_base));
    p_tx_base_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_state != 2'b00) |=> $stable(tx_ring_base));
    p_rst_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (soft_reset && !reset_done) |=> soft_reset);
    p_rst_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (reset_done && !(bus_wr && bus_addr == OFF_MODE)) |=> !soft_reset);
    p_align_r8: assert property (@(posedge clk) disable iff (rst)
        rx_ring_base[1:0] == 2'b00 && tx_ring_base[1:0] == 2'b00);
    p_poll_read_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_TX_POLL || bus_addr == OFF_RX_POLL) |-> bus_rdata == '1);
endmodule

bind dma_csr_regs dma_csr_regs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .tx_state     (tx_state),
    .rx_state     (rx_state),
    .reset_done   (reset_done),
    .big_endian   (big_endian),
    .desc_gap     (desc_gap),
    .tx_first     (tx_first),
    .soft_reset   (soft_reset),
    .tx_poll      (tx_poll),
    .rx_poll      (rx_poll),
    .rx_ring_base (rx_ring_base),
    .tx_ring_base (tx_ring_base)
);

// File: tb/dma_csr_regs_test.sv
module dma_csr_regs_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  tx_state = 2'b00;
    logic [1:0]  rx_state = 2'b00;
    logic        reset_done = 1'b0;
    logic        big_endian, tx_first, soft_reset, tx_poll, rx_poll;
    logic [4:0]  desc_gap;
    logic [31:0] rx_ring_base, tx_ring_base;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_csr_regs uut (.*);

    // {req[79:76], addr[75:68], wdata[67:36], tx[35:34], rx[33:32], expected readback[31:0]}
    localparam logic [79:0] VEC [12] = '{
        {4'd2,  8'h00, 32'h0000_00FE, 2'b00, 2'b00, 32'h0000_00FE}, // R2 all fields set
        {4'd3,  8'h00, 32'h0000_0014, 2'b01, 2'b00, 32'h0000_00FE}, // R3 tx running
        {4'd3,  8'h00, 32'h0000_0014, 2'b00, 2'b10, 32'h0000_00FE}, // R3 rx suspended
        {4'd3,  8'h00, 32'h0000_0014, 2'b11, 2'b00, 32'h0000_00FE}, // R3 code 11
        {4'd2,  8'h00, 32'hFFFF_FF14, 2'b00, 2'b00, 32'h0000_0014}, // R2 gap 5, upper bits dropped
        {4'd8,  8'h18, 32'hDEAD_BEEF, 2'b10, 2'b00, 32'hDEAD_BEEC}, // R8 rx stopped, tx suspended
        {4'd8,  8'h18, 32'h1234_5678, 2'b00, 2'b01, 32'hDEAD_BEEC}, // R8 rx running
        {4'd9,  8'h20, 32'hCAFE_F00D, 2'b00, 2'b10, 32'hCAFE_F00C}, // R9 tx stopped
        {4'd9,  8'h20, 32'h1111_1111, 2'b10, 2'b00, 32'hCAFE_F00C}, // R9 tx suspended
        {4'd7,  8'h08, 32'h0000_0000, 2'b00, 2'b00, 32'hFFFF_FFFF}, // R7 tx poll read
        {4'd7,  8'h10, 32'h0000_0000, 2'b00, 2'b00, 32'hFFFF_FFFF}, // R7 rx poll read
        {4'd10, 8'h30, 32'hFFFF_FFFF, 2'b00, 2'b00, 32'h0000_0000}  // R10 unmapped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs", {big_endian, desc_gap, tx_first, soft_reset, tx_poll, rx_poll},
              32'h0);
        check("R1 rx base", rx_ring_base, 32'h0);
        check("R1 tx base", tx_ring_base, 32'h0);
        rd(8'h00, r);
        check("R1 mode read", r, 32'h0);

        // table walk (R2, R3, R7, R8, R9, R10, read path R11)
        for (int i = 0; i < 12; i++) begin
            tx_state = VEC[i][35:34];
            rx_state = VEC[i][33:32];
            wr(VEC[i][75:68], VEC[i][67:36]);
            rd(VEC[i][75:68], r);
            checks++;
            if (r !== VEC[i][31:0]) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual=%h expected=%h",
                         VEC[i][79:76], i, r, VEC[i][31:0]);
            end
            @(negedge clk);
        end
        tx_state = 2'b00;
        rx_state = 2'b00;

        // R10 unmapped write left everything alone
        rd(8'h00, r);
        check("R10 mode kept", r, 32'h14);
        check("R10 bases kept", rx_ring_base ^ tx_ring_base, 32'hDEAD_BEEC ^ 32'hCAFE_F00C);
        check("R2 outputs", {big_endian, desc_gap, tx_first}, {1'b0, 5'd5, 1'b0});

        // R11 combinational read: switch address, same cycle
        rd(8'h20, r);
        check("R11 tx base read", r, 32'hCAFE_F00C);

        // R5 tx poll pulse
        tx_state = 2'b10;
        wr(8'h08, 32'h5A5A_0000);
        check("R5 strobe high", {31'b0, tx_poll}, 32'h1);
        check("R5 rx quiet", {31'b0, rx_poll}, 32'h0);
        @(negedge clk);
        check("R5 strobe one cycle", {31'b0, tx_poll}, 32'h0);
        tx_state = 2'b01;
        wr(8'h08, 32'h0);
        check("R5 no strobe running", {31'b0, tx_poll}, 32'h0);
        tx_state = 2'b00;

        // R6 rx poll pulse
        rx_state = 2'b10;
        wr(8'h10, 32'hFFFF_FFFF);
        check("R6 strobe high", {31'b0, rx_poll}, 32'h1);
        check("R6 tx quiet", {31'b0, tx_poll}, 32'h0);
        @(negedge clk);
        check("R6 strobe one cycle", {31'b0, rx_poll}, 32'h0);
        rx_state = 2'b00;
        wr(8'h10, 32'h1);
        check("R6 no strobe stopped", {31'b0, rx_poll}, 32'h0);

        // R4 software reset request
        wr(8'h00, 32'h0000_0001);
        check("R4 set", {31'b0, soft_reset}, 32'h1);
        repeat (3) @(negedge clk);
        check("R4 held", {31'b0, soft_reset}, 32'h1);
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, r);
        check("R4 zero write ignored", r, 32'h1);
        reset_done = 1'b1;
        @(negedge clk);
        reset_done = 1'b0;
        check("R4 cleared", {31'b0, soft_reset}, 32'h0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule